// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage with Two-Edge Deselect

This block sits between the storage array of a synchronous SRAM and its data pins. It accepts per-cycle read and deselect commands, takes the array's read word in the cycle after the read is sampled, and presents that word on the output. A run-time mode pin selects one of two timings. In flow-through timing the array word goes straight to the output. In pipelined timing the word first passes through a rising-edge output register. A burst therefore costs 2-1-1-1 clocks in flow-through timing and 3-1-1-1 clocks in pipelined timing.

Output drive is part of the same pipeline. A read turns drive on and a deselect turns it off, and each takes effect at the same depth as the data. In pipelined timing, drive therefore stays on for one full cycle after a deselect is sampled and drops only after the second rising edge. Any beat already in flight is still presented with drive on. An asynchronous output-enable removes drive at once, whatever the pipeline holds.

The output side is a stream with a valid flag and no ready. The block cannot stall, so the consumer must take every beat in the one cycle it is presented. The array must place the word for a read sampled on edge E on `arr_data` during the cycle after E.

Top module: `sram_rdout_pipe`

## Requirements
- R1: After reset, with no command yet sampled, `out_valid` and `out_drive` are both 0.
- R2: With `pipe_mode`=0, a read sampled on edge E is presented on `out_data` with `out_valid`=1 during the cycle that follows E.
- R3: With `pipe_mode`=1, `arr_data` is captured on edge E+1 for a read sampled on edge E. The word is then presented with `out_valid`=1 during the cycle that follows E+1.
- R4: Reads on consecutive edges give one beat per cycle, in issue order, with no gap. Each beat is shown for exactly one cycle and there is no back-pressure.
- R5: With `pipe_mode`=1, a deselect sampled on edge E leaves `out_drive` unchanged during the cycle after E. `out_drive` is 0 after edge E+1.
- R6: With `pipe_mode`=0, a deselect sampled on edge E makes `out_drive` 0 after edge E.
- R7: A deselect that follows a read never removes drive from that read's beat: every cycle with `out_valid`=1 and `oe`=1 has `out_drive`=1.
- R8: When `cmd_read` and `cmd_desel` are both 1 on one edge, the deselect wins. No beat is produced for that read, and drive turns off as in R5/R6.
- R9: `oe`=0 forces `out_drive` to 0 without waiting for a clock edge. `out_valid` and `out_data` are not affected.
- R10: After a read, drive stays on through idle cycles (neither command) until a deselect reaches the output.
- R11: `pipe_mode` may change only while no read is in flight. The new timing then applies from the next read on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_read | input | 1 | Read command, sampled on the rising edge |
| cmd_desel | input | 1 | Deselect command, sampled on the rising edge; wins over a read |
| pipe_mode | input | 1 | 1 = pipelined timing, 0 = flow-through timing |
| oe | input | 1 | Asynchronous output enable, active high |
| arr_data | input | DATA_W | Array word for the read sampled on the previous edge |
| out_data | output | DATA_W | Presented read word |
| out_valid | output | 1 | A read beat is presented this cycle |
| out_drive | output | 1 | Data pins are driven this cycle |

## Verification
A deselect and a beat from an earlier read can occupy the output in the same cycle. In pipelined timing the cycle right after the deselect is sampled carries the last beat of the burst. The bench provokes this by issuing a deselect on the edge directly after the final read of a back-to-back burst. It judges the result on two points: the scoreboard must still receive that beat on its due cycle with drive on, and drive must be off one cycle later. A read and a deselect sampled on the same edge are also tried. There the bench expects the beat to be absent and drive to drop at deselect timing.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_DESEL = 2'd2
  } rdo_cmd_e;
endpackage

// File: rtl/rdo_cmd_stage.sv
// First stage: decodes the command (deselect wins) and tracks drive state.
module rdo_cmd_stage
  import rdo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_read,
  input  logic cmd_desel,
  output logic s1_read,
  output logic s1_drv
);
  rdo_cmd_e cmd;

  always_comb begin
    if (cmd_desel)     cmd = CMD_DESEL;
    else if (cmd_read) cmd = CMD_READ;
    else               cmd = CMD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_read <= 1'b0;
      s1_drv  <= 1'b0;
    end else begin
      s1_read <= (cmd == CMD_READ);
      case (cmd)
        CMD_READ:  s1_drv <= 1'b1;
        CMD_DESEL: s1_drv <= 1'b0;
        default:   s1_drv <= s1_drv;
      endcase
    end
  end
endmodule

// File: rtl/rdo_out_reg.sv
// Output register: captures the array word and the flags one edge later.
module rdo_out_reg #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_read,
  input  logic              in_drv,
  input  logic [DATA_W-1:0] in_data,
  output logic              q_read,
  output logic              q_drv,
  output logic [DATA_W-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_read <= 1'b0;
      q_drv  <= 1'b0;
      q_data <= '0;
    end else begin
      q_read <= in_read;
      q_drv  <= in_drv;
      if (in_read) q_data <= in_data;
    end
  end
endmodule

// File: rtl/sram_rdout_pipe.sv
module sram_rdout_pipe #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_read,
  input  logic              cmd_desel,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_drive
);
  logic              s1_read, s1_drv;
  logic              s2_read, s2_drv;
  logic [DATA_W-1:0] s2_data;
  logic              sel_drv;

  rdo_cmd_stage u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_read  (cmd_read),
    .cmd_desel (cmd_desel),
    .s1_read   (s1_read),
    .s1_drv    (s1_drv)
  );

  rdo_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_read (s1_read),
    .in_drv  (s1_drv),
    .in_data (arr_data),
    .q_read  (s2_read),
    .q_drv   (s2_drv),
    .q_data  (s2_data)
  );

  // Timing select: flow-through bypasses the output register.
  always_comb begin
    if (pipe_mode) begin
      out_data  = s2_data;
      out_valid = s2_read;
      sel_drv   = s2_drv;
    end else begin
      out_data  = arr_data;
      out_valid = s1_read;
      sel_drv   = s1_drv;
    end
    out_drive = sel_drv & oe;
  end
endmodule

module sram_rdout_pipe_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_read,
  input logic              cmd_desel,
  input logic              pipe_mode,
  input logic              oe,
  input logic [DATA_W-1:0] arr_data,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_drive
);
  assert_flow_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_read && !cmd_desel && !pipe_mode) |=> out_valid);

  assert_pipe_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_read && !cmd_desel && pipe_mode) |=> ##1 (out_valid && out_data == $past(arr_data)));

  assert_pipe_desel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_desel && pipe_mode) |=> ##1 !out_drive);

  assert_flow_desel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_desel && !pipe_mode) |=> !out_drive);

  assert_beat_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && oe) |-> out_drive);

  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !out_drive);

  assert_mode_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_read |=> $stable(pipe_mode));
endmodule

bind sram_rdout_pipe sram_rdout_pipe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .cmd_desel(cmd_desel),
  .pipe_mode(pipe_mode), .oe(oe), .arr_data(arr_data), .out_data(out_data),
  .out_valid(out_valid), .out_drive(out_drive)
);

// File: tb/sram_rdout_pipe_test.sv
module sram_rdout_pipe_test;
  localparam int DATA_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_read = 1'b0;
  logic              cmd_desel = 1'b0;
  logic              pipe_mode = 1'b0;
  logic              oe = 1'b1;
  logic [DATA_W-1:0] arr_data = '0;
  logic [DATA_W-1:0] nxt_val = '0;
  logic [DATA_W-1:0] out_data;
  logic              out_valid, out_drive;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DATA_W-1:0] data;
    int                due;
    bit                piped;
  } beat_t;
  beat_t sb[$];

  always #10 clk = ~clk;

  sram_rdout_pipe #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .cmd_desel(cmd_desel),
    .pipe_mode(pipe_mode), .oe(oe), .arr_data(arr_data),
    .out_data(out_data), .out_valid(out_valid), .out_drive(out_drive)
  );

  // Array model: the word for a read appears in the cycle after it is sampled.
  always @(posedge clk) begin
    arr_data <= nxt_val;
    cyc      <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: sets one cycle of commands; a surviving read goes to the scoreboard.
  task automatic step(input bit rd, input bit ds, input logic [DATA_W-1:0] val);
    beat_t b;
    cmd_read  = rd;
    cmd_desel = ds;
    nxt_val   = val;
    if (rd && !ds) begin
      b.data  = val;
      b.due   = cyc + 1 + (pipe_mode ? 1 : 0);
      b.piped = pipe_mode;
      sb.push_back(b);
    end
    @(negedge clk);
    cmd_read  = 1'b0;
    cmd_desel = 1'b0;
  endtask

  // Monitor: every presented beat must match the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected beat", int'(out_data), -1);
      end else begin
        beat_t e;
        e = sb.pop_front();
        check(out_data == e.data, e.piped ? "R3 data" : "R2 data",
              int'(out_data), int'(e.data));
        check(cyc == e.due, e.piped ? "R3/R4 cycle" : "R2/R4 cycle", cyc, e.due);
        if (oe) check(out_drive == 1'b1, "R7 beat driven", int'(out_drive), 1);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    check(out_drive == 1'b0, "R1 drive", int'(out_drive), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_drive == 1'b0, "R1 drive idle", int'(out_drive), 0);

    // Flow-through burst, idle hold, then deselect.
    pipe_mode = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 18'h100 + i);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0);
    check(out_drive == 1'b1, "R10 drive held", int'(out_drive), 1);
    step(1'b0, 1'b1, '0);
    check(out_drive == 1'b0, "R6 flow desel", int'(out_drive), 0);
    step(1'b0, 1'b0, '0);

    // Mode change while idle; pipelined burst with deselect on its tail.
    pipe_mode = 1'b1;
    step(1'b0, 1'b0, '0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 18'h2A0 + i);
    step(1'b0, 1'b1, '0);
    check(out_drive == 1'b1, "R5 drive held one cycle", int'(out_drive), 1);
    check(out_valid == 1'b1, "R7 last beat present", int'(out_valid), 1);
    step(1'b0, 1'b0, '0);
    check(out_drive == 1'b0, "R5 drive off after second edge", int'(out_drive), 0);
    step(1'b0, 1'b0, '0);

    // Read and deselect on the same edge: no beat, drive drops.
    step(1'b1, 1'b0, 18'h3C1);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    check(out_drive == 1'b1, "R10 pipe drive held", int'(out_drive), 1);
    step(1'b1, 1'b1, 18'h3FF);
    check(out_drive == 1'b1, "R8 drive before drop", int'(out_drive), 1);
    step(1'b0, 1'b0, '0);
    check(out_drive == 1'b0, "R8 drive off", int'(out_drive), 0);
    check(out_valid == 1'b0, "R8 no beat", int'(out_valid), 0);
    step(1'b0, 1'b0, '0);

    // Asynchronous output enable during a valid pipelined beat.
    step(1'b1, 1'b0, 18'h155);
    step(1'b0, 1'b0, '0);
    check(out_valid == 1'b1, "R9 beat present", int'(out_valid), 1);
    #2 oe = 1'b0;
    #1;
    check(out_drive == 1'b0, "R9 drive forced off", int'(out_drive), 0);
    check(out_valid == 1'b1, "R9 valid unaffected", int'(out_valid), 1);
    check(out_data == 18'h155, "R9 data unaffected", int'(out_data), 'h155);
    #1 oe = 1'b1;
    #1;
    check(out_drive == 1'b1, "R9 drive restored", int'(out_drive), 1);
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);

    // Back to flow-through with a gapped pattern.
    pipe_mode = 1'b0;
    step(1'b0, 1'b0, '0);
    step(1'b1, 1'b0, 18'h011);
    step(1'b0, 1'b0, '0);
    step(1'b1, 1'b0, 18'h022);
    step(1'b1, 1'b0, 18'h033);
    step(1'b0, 1'b1, '0);
    check(out_drive == 1'b0, "R11 flow timing after switch", int'(out_drive), 0);
    repeat (3) step(1'b0, 1'b0, '0);

    check(sb.size() == 0, "R4 all beats seen", sb.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule